// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside an 8-bit processor core and decides, at each instruction boundary, whether the core must break off to service an interrupt. It watches five request sources: a non-maskable line, three maskable restart lines and a general request line. It picks the most urgent one that is allowed to run. For a restart source it presents a fixed vector address. For the general request it raises an acknowledge, and the requesting device then drives the opcode onto the bus itself.

Software controls the unit through two 8-bit register formats. The mask-set word loads the three restart masks, clears the edge-capture flag, and sets a serial output bit. The mask-read word returns the masks, the global enable, the raw pending state of the three restart sources and the serial input pin. The global enable is turned off by a disable strobe and by every accepted interrupt. It is turned on by an enable strobe, which takes effect only one instruction later. This lets a handler finish its return before it can be interrupted again.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, all three restart masks are set, the global enable is clear, the serial output is 0, and neither output pulse is active. With all pins low, the mask-read word reads 0x07.
- R2: On acceptance, `vec_valid` pulses for one cycle, in the cycle after the boundary, and `vec_addr` gives the vector: 0x24 for the non-maskable line, 0x2C for the low level line, 0x34 for the high level line and 0x3C for the edge line.
- R3: Requests are considered only at an `insn_end` pulse. When several requests are eligible, the winner follows this order from highest to lowest: non-maskable, edge, high level, low level, general.
- R4: The non-maskable line is accepted regardless of the masks and the global enable. It is accepted only if it has risen and is still high at the boundary. After acceptance it is not taken again until a new rising edge.
- R5: The low and high level lines are eligible only while they are high, unmasked and enabled.
- R6: A rising edge on the edge line sets a flag whether or not that line is masked, and the flag remains set after the pin falls. The flag is cleared when its interrupt is accepted, or by a mask-set write with bit 4 = 1.
- R7: The general request, when it wins, pulses `ext_ack` in the cycle after the boundary instead of `vec_valid`. The general request needs the global enable.
- R8: Accepting any interrupt clears the global enable.
- R9: When the enable strobe arrives in the middle of an instruction, the boundary that ends that instruction accepts nothing. The boundary after it accepts, and sets the enable. When the strobe arrives in the same cycle as a boundary, that boundary counts as the end of the enabling instruction.
- R10: The disable strobe clears the global enable at the next clock. A disable arriving in the same cycle as an enable wins.
- R11: A mask-set write loads masks from bits 2..0 (bit 0 for the low level line, bit 1 for the high level line, bit 2 for the edge line; 1 = masked) only when bit 3 is 1. Otherwise the masks are unchanged.
- R12: A mask-set write loads `serial_out` from bit 7 only when bit 6 is 1.
- R13: `mread_data` gives: bits 2..0 = the masks; bit 3 = the global enable; bit 4 = the low level pin; bit 5 = the high level pin; bit 6 = the edge flag; bit 7 = `serial_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_nmi | input | 1 | Non-maskable request, edge plus level |
| req_edge | input | 1 | Rising-edge restart request |
| req_lvl_hi | input | 1 | High-priority level restart request |
| req_lvl_lo | input | 1 | Low-priority level restart request |
| req_ext | input | 1 | General request answered by acknowledge |
| ie_set | input | 1 | Enable strobe (delayed effect) |
| ie_clr | input | 1 | Disable strobe |
| insn_end | input | 1 | Instruction-boundary pulse |
| mset_wr | input | 1 | Mask-set write strobe |
| mset_data | input | 8 | Mask-set word |
| mread_data | output | 8 | Mask-read word |
| serial_in | input | 1 | Serial input pin |
| serial_out | output | 1 | Serial output latch |
| vec_valid | output | 1 | One-cycle pulse: restart vector accepted |
| vec_addr | output | VEC_W | Vector address of the last accepted restart |
| ext_ack | output | 1 | One-cycle acknowledge for the general request |

## Verification
The bench targets the one-instruction delay of the enable strobe. A design that enabled at once would accept a pending level request at the boundary of the enabling instruction itself. It also exercises a short pulse on the non-maskable line that is gone by the boundary. A design that tested only the edge would take it, and a design that did not clear its capture on acceptance would take a held line twice. The edge flag is checked while masked and after a clear written through the mask-set word. A wrong design would either lose the event or fire after software dismissed it. Writes with the mask-set or serial enable bits clear are checked for leaving state unchanged. A full five-way contention is resolved one source per boundary to expose any error in the priority order.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   // Source index doubles as priority: lower index wins.
   typedef enum logic [2:0] {
      SRC_NMI    = 3'd0,
      SRC_EDGE   = 3'd1,
      SRC_LVL_HI = 3'd2,
      SRC_LVL_LO = 3'd3,
      SRC_EXT    = 3'd4
   } irq_src_e;

   localparam int N_SRC = 5;

   // Mask-set word fields
   localparam int MS_MASK_EN  = 3;
   localparam int MS_EDGE_CLR = 4;
   localparam int MS_SOUT_EN  = 6;
   localparam int MS_SOUT     = 7;

   // Restart slot number (half-slot sources sit between whole slots)
   function automatic int unsigned src_slot(input int unsigned idx);
      case (idx)
         0:       return 4;
         1:       return 7;
         2:       return 6;
         3:       return 5;
         default: return 0;
      endcase
   endfunction

   // Vector of a half-slot source: spacing * slot + spacing / 2
   function automatic logic [31:0] half_slot_vec(input int unsigned idx,
                                                 input int unsigned spacing);
      return 32'(spacing * src_slot(idx) + spacing / 2);
   endfunction

endpackage

// File: rtl/irqv_edge_latch.sv
module irqv_edge_latch #(
   parameter bit HOLD_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic clr,
   output logic pend
);
   logic prev_q;
   logic seen_q;
   logic rise;

   assign rise = pin & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin;
   end

   generate
      if (HOLD_LEVEL) begin : g_hold
         // Capture is dropped as soon as the pin falls.
         always_ff @(posedge clk) begin
            if (!rst_n)                seen_q <= 1'b0;
            else if (rise)             seen_q <= 1'b1;
            else if (clr || !pin)      seen_q <= 1'b0;
         end
         assign pend = seen_q & pin;
      end else begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n)      seen_q <= 1'b0;
            else if (rise)   seen_q <= 1'b1;
            else if (clr)    seen_q <= 1'b0;
         end
         assign pend = seen_q;
      end
   endgenerate
endmodule

// File: rtl/irqv_mask_ctl.sv
module irqv_mask_ctl #(
   parameter int MASK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [MASK_W-1:0] wmask,
   input  logic              mask_en,
   input  logic              sout_en,
   input  logic              sout_bit,
   output logic [MASK_W-1:0] mask,
   output logic              sout
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= '1;
         sout <= 1'b0;
      end else if (wr) begin
         if (mask_en) mask <= wmask;
         if (sout_en) sout <= sout_bit;
      end
   end
endmodule

// File: rtl/irqv_enable_ctl.sv
module irqv_enable_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic boundary,
   input  logic taken,
   output logic ie,
   output logic en_eff
);
   typedef enum logic [1:0] {
      EN_IDLE      = 2'd0,
      EN_WAIT_OWN  = 2'd1,
      EN_WAIT_NEXT = 2'd2
   } en_state_e;

   en_state_e st_q;

   assign en_eff = ie | ((st_q == EN_WAIT_NEXT) & boundary);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie   <= 1'b0;
         st_q <= EN_IDLE;
      end else if (clr || taken) begin
         ie   <= 1'b0;
         st_q <= EN_IDLE;
      end else if (set && !ie) begin
         st_q <= boundary ? EN_WAIT_NEXT : EN_WAIT_OWN;
      end else if (boundary) begin
         case (st_q)
            EN_WAIT_OWN:  st_q <= EN_WAIT_NEXT;
            EN_WAIT_NEXT: begin
               ie   <= 1'b1;
               st_q <= EN_IDLE;
            end
            default:      st_q <= EN_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] blocked;

   assign blocked[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_stage
         assign grant[i]     = req[i] & ~blocked[i];
         assign blocked[i+1] = blocked[i] | req[i];
      end
   endgenerate

   assign any = blocked[N];
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
   parameter int VEC_W       = 16,
   parameter int SLOT_SPAN   = 8,
   parameter int MASK_W      = 3,
   parameter int REG_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_nmi,
   input  logic             req_edge,
   input  logic             req_lvl_hi,
   input  logic             req_lvl_lo,
   input  logic             req_ext,
   input  logic             ie_set,
   input  logic             ie_clr,
   input  logic             insn_end,
   input  logic             mset_wr,
   input  logic [REG_W-1:0] mset_data,
   output logic [REG_W-1:0] mread_data,
   input  logic             serial_in,
   output logic             serial_out,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_addr,
   output logic             ext_ack
);
   import irqv_pkg::*;

   localparam int MAX_VEC = SLOT_SPAN * 7 + SLOT_SPAN / 2;

   generate
      if (MAX_VEC >= (1 << VEC_W)) begin : g_bad_vec_w
         $error("VEC_W too narrow for the highest vector");
      end
      if ((SLOT_SPAN < 2) || (SLOT_SPAN % 2 != 0)) begin : g_bad_span
         $error("SLOT_SPAN must be even and at least 2");
      end
      if (MASK_W != 3 || REG_W != 8) begin : g_bad_fmt
         $error("register formats assume three masks in an 8-bit word");
      end
   endgenerate

   logic              nmi_pend, edge_flag;
   logic [MASK_W-1:0] mask;
   logic              ie, en_eff;
   logic [N_SRC-1:0]  req_vec, grant;
   logic              any_req, accept, edge_clr_sw;
   logic [VEC_W-1:0]  vec_tab [N_SRC];
   logic [VEC_W-1:0]  vec_sel;
   logic              mset_unused_bit;

   assign mset_unused_bit = mset_data[5];
   assign edge_clr_sw     = mset_wr & mset_data[MS_EDGE_CLR];

   irqv_edge_latch #(.HOLD_LEVEL(1'b1)) i_nmi_cap (
      .clk(clk), .rst_n(rst_n), .pin(req_nmi),
      .clr(accept & grant[SRC_NMI]), .pend(nmi_pend)
   );

   irqv_edge_latch #(.HOLD_LEVEL(1'b0)) i_edge_cap (
      .clk(clk), .rst_n(rst_n), .pin(req_edge),
      .clr((accept & grant[SRC_EDGE]) | edge_clr_sw), .pend(edge_flag)
   );

   irqv_mask_ctl #(.MASK_W(MASK_W)) i_mask (
      .clk(clk), .rst_n(rst_n), .wr(mset_wr),
      .wmask(mset_data[MASK_W-1:0]),
      .mask_en(mset_data[MS_MASK_EN]),
      .sout_en(mset_data[MS_SOUT_EN]),
      .sout_bit(mset_data[MS_SOUT]),
      .mask(mask), .sout(serial_out)
   );

   irqv_enable_ctl i_enable (
      .clk(clk), .rst_n(rst_n), .set(ie_set), .clr(ie_clr),
      .boundary(insn_end), .taken(accept), .ie(ie), .en_eff(en_eff)
   );

   assign req_vec[SRC_NMI]    = nmi_pend;
   assign req_vec[SRC_EDGE]   = edge_flag  & ~mask[2] & en_eff;
   assign req_vec[SRC_LVL_HI] = req_lvl_hi & ~mask[1] & en_eff;
   assign req_vec[SRC_LVL_LO] = req_lvl_lo & ~mask[0] & en_eff;
   assign req_vec[SRC_EXT]    = req_ext    & en_eff;

   irqv_prio_pick #(.N(N_SRC)) i_pick (
      .req(req_vec), .grant(grant), .any(any_req)
   );

   assign accept = insn_end & any_req;

   generate
      for (genvar s = 0; s < N_SRC; s++) begin : g_vec
         localparam logic [31:0] VEC_FULL = half_slot_vec(s, SLOT_SPAN);
         if (s == int'(SRC_EXT)) begin : g_none
            assign vec_tab[s] = '0;
         end else begin : g_rst
            assign vec_tab[s] = VEC_FULL[VEC_W-1:0];
         end
      end
   endgenerate

   always_comb begin
      vec_sel = '0;
      for (int s = 0; s < N_SRC; s++) begin
         if (grant[s]) vec_sel = vec_sel | vec_tab[s];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         ext_ack   <= 1'b0;
         vec_addr  <= '0;
      end else begin
         vec_valid <= accept & ~grant[SRC_EXT];
         ext_ack   <= accept &  grant[SRC_EXT];
         if (accept && !grant[SRC_EXT]) vec_addr <= vec_sel;
      end
   end

   assign mread_data = {serial_in, edge_flag, req_lvl_hi, req_lvl_lo, ie, mask};
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
   parameter int VEC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             insn_end,
   input logic             mset_wr,
   input logic [7:0]       mset_data,
   input logic [7:0]       mread_data,
   input logic             serial_out,
   input logic             vec_valid,
   input logic [VEC_W-1:0] vec_addr,
   input logic             ext_ack
);
   p_boundary_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid || ext_ack) |-> $past(insn_end));

   p_single_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(vec_valid && ext_ack));

   p_accept_drops_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid || ext_ack) |-> !mread_data[3]);

   p_vector_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_addr == 'h24 || vec_addr == 'h2C ||
                     vec_addr == 'h34 || vec_addr == 'h3C));

   p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mset_wr && mset_data[3]) |=> $stable(mread_data[2:0]));

   p_sout_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mset_wr && mset_data[6]) |=> $stable(serial_out));
endmodule

bind irq_vector_unit irqv_checker #(.VEC_W(VEC_W)) i_irqv_checker (
   .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .mset_wr(mset_wr),
   .mset_data(mset_data), .mread_data(mread_data), .serial_out(serial_out),
   .vec_valid(vec_valid), .vec_addr(vec_addr), .ext_ack(ext_ack)
);

// File: tb/test_irq_vector_unit.sv
module test_irq_vector_unit;
   localparam int VW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_nmi = 0, req_edge = 0, req_lvl_hi = 0, req_lvl_lo = 0, req_ext = 0;
   logic          ie_set = 0, ie_clr = 0, insn_end = 0, mset_wr = 0, serial_in = 0;
   logic [7:0]    mset_data = '0;
   logic [7:0]    mread_data;
   logic          serial_out, vec_valid, ext_ack;
   logic [VW-1:0] vec_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_vector_unit #(.VEC_W(VW)) i_irq_vector_unit (
      .clk(clk), .rst_n(rst_n), .req_nmi(req_nmi), .req_edge(req_edge),
      .req_lvl_hi(req_lvl_hi), .req_lvl_lo(req_lvl_lo), .req_ext(req_ext),
      .ie_set(ie_set), .ie_clr(ie_clr), .insn_end(insn_end),
      .mset_wr(mset_wr), .mset_data(mset_data), .mread_data(mread_data),
      .serial_in(serial_in), .serial_out(serial_out), .vec_valid(vec_valid),
      .vec_addr(vec_addr), .ext_ack(ext_ack)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic boundary();
      insn_end = 1'b1;
      tick();
      insn_end = 1'b0;
   endtask

   task automatic mset(input logic [7:0] d);
      mset_wr = 1'b1; mset_data = d;
      tick();
      mset_wr = 1'b0; mset_data = '0;
   endtask

   // Enable strobe mid-instruction, then end that instruction.
   task automatic open_ints();
      ie_set = 1'b1;
      tick();
      ie_set = 1'b0;
      boundary();
   endtask

   task automatic expect_vec(input string req, input logic [VW-1:0] v);
      chk({req, " vec_valid"}, vec_valid, 1);
      chk({req, " vec_addr"}, vec_addr, v);
      chk({req, " no ext_ack"}, ext_ack, 0);
   endtask

   task automatic expect_none(input string req);
      chk({req, " no vec_valid"}, vec_valid, 0);
      chk({req, " no ext_ack"}, ext_ack, 0);
   endtask

   task automatic t_reset();
      chk("R1 mread", mread_data, 8'h07);
      chk("R1 serial_out", serial_out, 0);
      expect_none("R1");
   endtask

   task automatic t_delayed_enable();
      mset(8'h08);
      chk("R11 masks cleared", mread_data[2:0], 3'b000);
      req_lvl_lo = 1'b1;
      ie_set = 1'b1; tick(); ie_set = 1'b0;
      boundary();
      expect_none("R9 own boundary");
      chk("R9 ie still off", mread_data[3], 0);
      boundary();
      expect_vec("R9 R2 low level", 8'h2C);
      chk("R8 ie cleared", mread_data[3], 0);
      boundary();
      expect_none("R8 no retake");
      // strobe coinciding with the boundary
      ie_set = 1'b1; insn_end = 1'b1; tick(); ie_set = 1'b0; insn_end = 1'b0;
      expect_none("R9 coincident strobe");
      boundary();
      expect_vec("R9 next boundary", 8'h2C);
      req_lvl_lo = 1'b0;
   endtask

   task automatic t_disable();
      open_ints();
      boundary();
      chk("R10 ie on", mread_data[3], 1);
      ie_clr = 1'b1; tick(); ie_clr = 1'b0;
      chk("R10 ie off", mread_data[3], 0);
      req_ext = 1'b1;
      boundary();
      expect_none("R10 disabled ext");
      ie_set = 1'b1; ie_clr = 1'b1; tick(); ie_set = 1'b0; ie_clr = 1'b0;
      boundary(); boundary();
      chk("R10 clr beats set", mread_data[3], 0);
      expect_none("R10 clr beats set");
      req_ext = 1'b0;
   endtask

   task automatic t_ext();
      open_ints();
      req_ext = 1'b1;
      boundary();
      chk("R7 ext_ack", ext_ack, 1);
      chk("R7 no vec_valid", vec_valid, 0);
      open_ints();
      req_lvl_lo = 1'b1;
      boundary();
      expect_vec("R7 lowest priority", 8'h2C);
      req_ext = 1'b0; req_lvl_lo = 1'b0;
   endtask

   task automatic t_priority();
      open_ints();
      req_edge = 1'b1; tick(); req_edge = 1'b0;
      req_lvl_hi = 1'b1; req_lvl_lo = 1'b1; req_ext = 1'b1; req_nmi = 1'b1;
      tick();
      boundary();
      expect_vec("R3 nmi first", 8'h24);
      open_ints(); boundary();
      expect_vec("R3 R4 edge next, nmi held not retaken", 8'h3C);
      chk("R6 flag cleared on accept", mread_data[6], 0);
      open_ints(); boundary();
      expect_vec("R3 high level", 8'h34);
      req_lvl_hi = 1'b0;
      open_ints(); boundary();
      expect_vec("R3 low level", 8'h2C);
      req_lvl_lo = 1'b0;
      open_ints(); boundary();
      chk("R3 ext last", ext_ack, 1);
      req_ext = 1'b0; req_nmi = 1'b0;
      tick();
   endtask

   task automatic t_nmi();
      mset(8'h0F);
      req_nmi = 1'b1; tick();
      boundary();
      expect_vec("R4 nmi ignores mask and enable", 8'h24);
      req_nmi = 1'b0; tick();
      req_nmi = 1'b1; tick(); req_nmi = 1'b0; tick();
      boundary();
      expect_none("R4 short pulse dropped");
   endtask

   task automatic t_mask();
      open_ints();
      mset(8'h0B);
      req_lvl_lo = 1'b1; req_lvl_hi = 1'b1;
      boundary();
      expect_none("R5 masked levels");
      chk("R13 raw pending", mread_data[5:4], 2'b11);
      mset(8'h03);
      chk("R11 mask unchanged", mread_data[2:0], 3'b011);
      boundary();
      expect_none("R11 still masked");
      mset(8'h08);
      boundary();
      expect_vec("R5 unmasked high level", 8'h34);
      req_lvl_lo = 1'b0; req_lvl_hi = 1'b0;
      open_ints();
      boundary();
      expect_none("R5 levels low");
   endtask

   task automatic t_edge();
      mset(8'h0C);
      req_edge = 1'b1; tick(); req_edge = 1'b0; tick();
      chk("R6 flag kept while masked", mread_data[6], 1);
      open_ints();
      boundary();
      expect_none("R6 masked edge");
      mset(8'h10);
      chk("R6 sw clear", mread_data[6], 0);
      chk("R11 clear write keeps mask", mread_data[2:0], 3'b100);
      req_edge = 1'b1; tick(); req_edge = 1'b0;
      mset(8'h08);
      boundary();
      expect_vec("R6 R2 edge", 8'h3C);
      chk("R6 cleared after accept", mread_data[6], 0);
   endtask

   task automatic t_serial();
      mset(8'h80);
      chk("R12 no enable", serial_out, 0);
      mset(8'hC0);
      chk("R12 set", serial_out, 1);
      mset(8'h00);
      chk("R12 held", serial_out, 1);
      mset(8'h40);
      chk("R12 cleared", serial_out, 0);
      serial_in = 1'b1; tick();
      chk("R13 serial in bit", mread_data[7], 1);
      serial_in = 1'b0;
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_delayed_enable();
      t_disable();
      t_ext();
      t_priority();
      t_nmi();
      t_mask();
      t_edge();
      t_serial();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule